// File: doc/BRIEF.md
# Receiver Error Status and Interrupt Register Bank

This block is the software-facing register bank of a camera serial receiver. It holds the configuration the receiver needs: how many data lanes are active, a PHY shutdown bit, a PHY reset bit, a controller reset bit and a small PHY settings field. It also collects one-cycle error pulses from the lane, packet, line and frame checkers into two sticky status words.

Each status word has a mask word of the same width. A single level interrupt is raised while any status bit is set and its mask bit is clear. Software reads a status word to learn which errors occurred. That read also clears the word.

Access is through a 32-bit APB slave with no wait states. The checkers only produce pulses, and this block does no detection of its own.

Top module: `rx_err_bank`

## Requirements
- R1: After reset the lane count reads 1, and every other register, every configuration output and the interrupt are 0.
- R2: The lane count at offset 0x04 occupies bits [2:0]. A write is accepted only if the whole 32-bit write value lies between 1 and NUM_LANES. Any other write leaves the count unchanged.
- R3: Bit 0 at offset 0x08 drives the PHY shutdown output, bit 0 at 0x0C the PHY reset output and bit 0 at 0x10 the controller reset output. Bits [7:0] at 0x14 drive the PHY settings output. Each register reads back what was stored, and these outputs change only on a write.
- R4: Status word 1 at 0x20 holds the lane events. Bits [L-1:0] are sync-failure start-of-transmission errors, bits [2L-1:L] are recoverable start-of-transmission errors and bits [3L-1:2L] are escape-entry errors, where L is NUM_LANES and bit n within a group is lane n.
- R5: Status word 2 at 0x24 holds the channel events, with V equal to NUM_VC and bit n within a group meaning channel n. Bits [V-1:0] are checksum errors, [2V-1:V] are corrected header errors, [3V-1:2V] are unknown data types, [4V-1:3V] are frame start/end mismatches, [5V-1:4V] are frame sequence errors and [6V-1:5V] are frames holding bad data. Bit 6V is an uncorrectable header error.
- R6: Status bits are sticky. A read of a status word returns its value before the read and clears it, and leaves the other word untouched. An event that arrives in the cycle of that read stays set.
- R7: Masks are read/write at 0x28 (word 1) and 0x2C (word 2). A mask bit of 1 keeps that status bit out of the interrupt, but the status bit is still latched.
- R8: The interrupt is high exactly while some status bit with a clear mask bit is set. It is high in the cycle after the event pulse, and it drops in the cycle after the read or mask write that removes the last such bit.
- R9: The version register at 0x00 reads VERSION (0 by default) and ignores writes. Writes to the status words have no effect. Offsets that are unmapped or not word aligned read 0 and ignore writes.
- R10: PREADY is always high, and read data is valid during the access phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| psel_i | input | 1 | APB select |
| penable_i | input | 1 | APB enable (access phase) |
| pwrite_i | input | 1 | APB write strobe |
| paddr_i | input | ADDR_W | APB byte address |
| pwdata_i | input | 32 | APB write data |
| prdata_o | output | 32 | APB read data |
| pready_o | output | 1 | APB ready, always high |
| sot_sync_err_i | input | NUM_LANES | Per-lane start-of-transmission error, sync failed |
| sot_err_i | input | NUM_LANES | Per-lane start-of-transmission error, recovered |
| esc_err_i | input | NUM_LANES | Per-lane escape-entry error |
| crc_err_i | input | NUM_VC | Per-channel payload checksum error |
| hdr_fix_i | input | NUM_VC | Per-channel single-bit header error corrected |
| dt_unknown_i | input | NUM_VC | Per-channel unknown data type |
| frm_match_err_i | input | NUM_VC | Per-channel frame start/end mismatch |
| frm_seq_err_i | input | NUM_VC | Per-channel frame sequence error |
| frm_data_err_i | input | NUM_VC | Per-channel frame had a checksum error |
| hdr_dbl_err_i | input | 1 | Uncorrectable header error |
| lanes_o | output | 3 | Active lane count |
| phy_shutdown_o | output | 1 | PHY shutdown control bit |
| phy_rst_o | output | 1 | PHY reset control bit |
| ctrl_rst_o | output | 1 | Controller reset control bit |
| phy_cfg_o | output | 8 | PHY settings field |
| irq_o | output | 1 | Level interrupt |

## Verification
Read data is combinational during the access phase, so the bench samples PRDATA one time unit after the falling edge that starts that phase. Configuration outputs and the clearing of a status word take effect at the rising edge that ends the access phase, so the bench checks them at the following falling edge. An event pulse is driven across one rising edge, and the interrupt is checked at the next falling edge, since the interrupt follows the status register with no added delay. For the same-cycle case, the event is driven in the access phase of a status read: the read must return the old value and a later read must show the bit.

// File: rtl/rxerr_pkg.sv
package rxerr_pkg;

  localparam int unsigned DATA_W = 32;

  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_VER,
    SEL_LANES,
    SEL_SHDN,
    SEL_PRST,
    SEL_CRST,
    SEL_PCFG,
    SEL_ERR1,
    SEL_ERR2,
    SEL_MSK1,
    SEL_MSK2
  } reg_sel_e;

  function automatic reg_sel_e decode_addr(input logic [31:0] a);
    reg_sel_e s;
    case (a)
      32'h00:  s = SEL_VER;
      32'h04:  s = SEL_LANES;
      32'h08:  s = SEL_SHDN;
      32'h0C:  s = SEL_PRST;
      32'h10:  s = SEL_CRST;
      32'h14:  s = SEL_PCFG;
      32'h20:  s = SEL_ERR1;
      32'h24:  s = SEL_ERR2;
      32'h28:  s = SEL_MSK1;
      32'h2C:  s = SEL_MSK2;
      default: s = SEL_NONE;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/rxerr_decode.sv
module rxerr_decode
  import rxerr_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              psel_i,
  input  logic              penable_i,
  input  logic              pwrite_i,
  input  logic [ADDR_W-1:0] paddr_i,
  output reg_sel_e          sel_o,
  output logic              rd_o,
  output logic              wr_o
);

  assign sel_o = decode_addr(32'(paddr_i));
  assign rd_o  = psel_i && penable_i && !pwrite_i;
  assign wr_o  = psel_i && penable_i && pwrite_i;

endmodule

// File: rtl/rxerr_cfg.sv
module rxerr_cfg
  import rxerr_pkg::*;
#(
  parameter int unsigned NUM_LANES = 4,
  parameter int unsigned STATE_W   = 8,
  localparam int unsigned LANE_W   = $clog2(NUM_LANES + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_i,
  input  reg_sel_e           sel_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [LANE_W-1:0]  lanes_o,
  output logic               shdn_o,
  output logic               prst_o,
  output logic               crst_o,
  output logic [STATE_W-1:0] pcfg_o
);

  logic lane_ok;
  assign lane_ok = (wdata_i != '0) && (wdata_i <= DATA_W'(NUM_LANES));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lanes_o <= LANE_W'(1);
      shdn_o  <= 1'b0;
      prst_o  <= 1'b0;
      crst_o  <= 1'b0;
      pcfg_o  <= '0;
    end else if (wr_i) begin
      case (sel_i)
        SEL_LANES: if (lane_ok) lanes_o <= wdata_i[LANE_W-1:0];
        SEL_SHDN:  shdn_o <= wdata_i[0];
        SEL_PRST:  prst_o <= wdata_i[0];
        SEL_CRST:  crst_o <= wdata_i[0];
        SEL_PCFG:  pcfg_o <= wdata_i[STATE_W-1:0];
        default:   ;
      endcase
    end
  end

endmodule

// File: rtl/rxerr_sticky.sv
module rxerr_sticky #(
  parameter int unsigned W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] evt_i,
  input  logic         clr_i,
  input  logic         mask_we_i,
  input  logic [W-1:0] mask_d_i,
  output logic [W-1:0] status_o,
  output logic [W-1:0] mask_o,
  output logic         irq_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_o <= '0;
      mask_o   <= '0;
    end else begin
      // new events win over the clear of the same cycle
      status_o <= (clr_i ? '0 : status_o) | evt_i;
      if (mask_we_i) mask_o <= mask_d_i;
    end
  end

  assign irq_o = |(status_o & ~mask_o);

endmodule

// File: rtl/rx_err_bank.sv
module rx_err_bank
  import rxerr_pkg::*;
#(
  parameter int unsigned NUM_LANES = 4,
  parameter int unsigned NUM_VC    = 4,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned STATE_W   = 8,
  parameter logic [31:0] VERSION   = 32'h0,
  localparam int unsigned LANE_W   = $clog2(NUM_LANES + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 psel_i,
  input  logic                 penable_i,
  input  logic                 pwrite_i,
  input  logic [ADDR_W-1:0]    paddr_i,
  input  logic [DATA_W-1:0]    pwdata_i,
  output logic [DATA_W-1:0]    prdata_o,
  output logic                 pready_o,
  input  logic [NUM_LANES-1:0] sot_sync_err_i,
  input  logic [NUM_LANES-1:0] sot_err_i,
  input  logic [NUM_LANES-1:0] esc_err_i,
  input  logic [NUM_VC-1:0]    crc_err_i,
  input  logic [NUM_VC-1:0]    hdr_fix_i,
  input  logic [NUM_VC-1:0]    dt_unknown_i,
  input  logic [NUM_VC-1:0]    frm_match_err_i,
  input  logic [NUM_VC-1:0]    frm_seq_err_i,
  input  logic [NUM_VC-1:0]    frm_data_err_i,
  input  logic                 hdr_dbl_err_i,
  output logic [LANE_W-1:0]    lanes_o,
  output logic                 phy_shutdown_o,
  output logic                 phy_rst_o,
  output logic                 ctrl_rst_o,
  output logic [STATE_W-1:0]   phy_cfg_o,
  output logic                 irq_o
);

  localparam int unsigned ERR1_W = 3 * NUM_LANES;
  localparam int unsigned ERR2_W = 6 * NUM_VC + 1;

  reg_sel_e sel;
  logic     rd, wr;

  rxerr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .psel_i   (psel_i),
    .penable_i(penable_i),
    .pwrite_i (pwrite_i),
    .paddr_i  (paddr_i),
    .sel_o    (sel),
    .rd_o     (rd),
    .wr_o     (wr)
  );

  rxerr_cfg #(.NUM_LANES(NUM_LANES), .STATE_W(STATE_W)) u_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (wr),
    .sel_i  (sel),
    .wdata_i(pwdata_i),
    .lanes_o(lanes_o),
    .shdn_o (phy_shutdown_o),
    .prst_o (phy_rst_o),
    .crst_o (ctrl_rst_o),
    .pcfg_o (phy_cfg_o)
  );

  // event packing, lowest group at bit 0
  logic [ERR1_W-1:0] phy_evt;
  logic [ERR2_W-1:0] proto_evt;
  assign phy_evt   = {esc_err_i, sot_err_i, sot_sync_err_i};
  assign proto_evt = {hdr_dbl_err_i, frm_data_err_i, frm_seq_err_i, frm_match_err_i,
                      dt_unknown_i, hdr_fix_i, crc_err_i};

  logic [ERR1_W-1:0] status1, mask1;
  logic [ERR2_W-1:0] status2, mask2;
  logic              irq1, irq2;

  rxerr_sticky #(.W(ERR1_W)) u_err1 (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .evt_i    (phy_evt),
    .clr_i    (rd && (sel == SEL_ERR1)),
    .mask_we_i(wr && (sel == SEL_MSK1)),
    .mask_d_i (pwdata_i[ERR1_W-1:0]),
    .status_o (status1),
    .mask_o   (mask1),
    .irq_o    (irq1)
  );

  rxerr_sticky #(.W(ERR2_W)) u_err2 (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .evt_i    (proto_evt),
    .clr_i    (rd && (sel == SEL_ERR2)),
    .mask_we_i(wr && (sel == SEL_MSK2)),
    .mask_d_i (pwdata_i[ERR2_W-1:0]),
    .status_o (status2),
    .mask_o   (mask2),
    .irq_o    (irq2)
  );

  assign irq_o    = irq1 | irq2;
  assign pready_o = 1'b1;

  always_comb begin
    prdata_o = '0;
    if (rd) begin
      case (sel)
        SEL_VER:   prdata_o = VERSION;
        SEL_LANES: prdata_o = DATA_W'(lanes_o);
        SEL_SHDN:  prdata_o = DATA_W'(phy_shutdown_o);
        SEL_PRST:  prdata_o = DATA_W'(phy_rst_o);
        SEL_CRST:  prdata_o = DATA_W'(ctrl_rst_o);
        SEL_PCFG:  prdata_o = DATA_W'(phy_cfg_o);
        SEL_ERR1:  prdata_o = DATA_W'(status1);
        SEL_ERR2:  prdata_o = DATA_W'(status2);
        SEL_MSK1:  prdata_o = DATA_W'(mask1);
        SEL_MSK2:  prdata_o = DATA_W'(mask2);
        default:   prdata_o = '0;
      endcase
    end
  end

endmodule

// File: rtl/rx_err_bank_chk.sv
module rx_err_bank_chk #(
  parameter int unsigned NUM_LANES = 4,
  parameter int unsigned NUM_VC    = 4,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned STATE_W   = 8,
  localparam int unsigned LANE_W   = $clog2(NUM_LANES + 1),
  localparam int unsigned ERR1_W   = 3 * NUM_LANES,
  localparam int unsigned ERR2_W   = 6 * NUM_VC + 1
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               psel_i,
  input logic               penable_i,
  input logic               pwrite_i,
  input logic [ADDR_W-1:0]  paddr_i,
  input logic [31:0]        prdata_o,
  input logic               irq_o,
  input logic [LANE_W-1:0]  lanes_o,
  input logic               phy_shutdown_o,
  input logic               phy_rst_o,
  input logic               ctrl_rst_o,
  input logic [STATE_W-1:0] phy_cfg_o,
  input logic [ERR1_W-1:0]  status1,
  input logic [ERR2_W-1:0]  status2,
  input logic [ERR1_W-1:0]  mask1,
  input logic [ERR2_W-1:0]  mask2,
  input logic [ERR1_W-1:0]  phy_evt,
  input logic [ERR2_W-1:0]  proto_evt
);

  localparam logic [ADDR_W-1:0] A_ERR1 = ADDR_W'(8'h20);
  localparam logic [ADDR_W-1:0] A_H18  = ADDR_W'(8'h18);
  localparam logic [ADDR_W-1:0] A_H1C  = ADDR_W'(8'h1C);
  localparam logic [ADDR_W-1:0] A_H30  = ADDR_W'(8'h30);

  logic acc, rd1;
  assign acc = psel_i && penable_i;
  assign rd1 = acc && !pwrite_i && (paddr_i == A_ERR1);

  assert_lane_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lanes_o >= LANE_W'(1)) && (lanes_o <= LANE_W'(NUM_LANES)));

  assert_cfg_stable_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(acc && pwrite_i) |=> $stable({lanes_o, phy_shutdown_o, phy_rst_o, ctrl_rst_o, phy_cfg_o}));

  assert_phy_latch_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phy_evt != '0) |=> ((status1 & $past(phy_evt)) == $past(phy_evt)));

  assert_proto_latch_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (proto_evt != '0) |=> ((status2 & $past(proto_evt)) == $past(proto_evt)));

  assert_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd1 |=> ((status1 & $past(status1)) == $past(status1)));

  assert_rd_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd1 && (phy_evt == '0)) |=> (status1 == '0));

  assert_full_mask_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((&mask1) && (&mask2)) |-> !irq_o);

  assert_irq_fall_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_o) |-> $past(acc));

  assert_unmapped_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && !pwrite_i && ((paddr_i == A_H18) || (paddr_i == A_H1C) || (paddr_i >= A_H30)))
    |-> (prdata_o == '0));

endmodule

bind rx_err_bank rx_err_bank_chk #(
  .NUM_LANES(NUM_LANES), .NUM_VC(NUM_VC), .ADDR_W(ADDR_W), .STATE_W(STATE_W)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .psel_i        (psel_i),
  .penable_i     (penable_i),
  .pwrite_i      (pwrite_i),
  .paddr_i       (paddr_i),
  .prdata_o      (prdata_o),
  .irq_o         (irq_o),
  .lanes_o       (lanes_o),
  .phy_shutdown_o(phy_shutdown_o),
  .phy_rst_o     (phy_rst_o),
  .ctrl_rst_o    (ctrl_rst_o),
  .phy_cfg_o     (phy_cfg_o),
  .status1       (status1),
  .status2       (status2),
  .mask1         (mask1),
  .mask2         (mask2),
  .phy_evt       (phy_evt),
  .proto_evt     (proto_evt)
);

// File: tb/rx_err_bank_bench.sv
`timescale 1ns/1ps
module rx_err_bank_bench;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        psel = 0, penable = 0, pwrite = 0;
  logic [7:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        pready;
  logic [3:0]  sy = '0, sh = '0, es = '0;
  logic [3:0]  crc = '0, fix = '0, unk = '0, fm = '0, fs = '0, fd = '0;
  logic        dbl = 1'b0;
  logic [2:0]  lanes;
  logic        shdn, prst, crst, irq;
  logic [7:0]  pcfg;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  rx_err_bank u_rx_err_bank (
    .clk_i(clk), .rst_ni(rst_ni),
    .psel_i(psel), .penable_i(penable), .pwrite_i(pwrite),
    .paddr_i(paddr), .pwdata_i(pwdata), .prdata_o(prdata), .pready_o(pready),
    .sot_sync_err_i(sy), .sot_err_i(sh), .esc_err_i(es),
    .crc_err_i(crc), .hdr_fix_i(fix), .dt_unknown_i(unk),
    .frm_match_err_i(fm), .frm_seq_err_i(fs), .frm_data_err_i(fd),
    .hdr_dbl_err_i(dbl),
    .lanes_o(lanes), .phy_shutdown_o(shdn), .phy_rst_o(prst), .ctrl_rst_o(crst),
    .phy_cfg_o(pcfg), .irq_o(irq)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", what, act, exp);
    end
  endtask

  task automatic apb_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
    @(negedge clk);
    penable = 1;
    @(negedge clk);
    psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic apb_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    psel = 1; pwrite = 0; paddr = a; penable = 0;
    @(negedge clk);
    penable = 1;
    #1 d = prdata;
    @(negedge clk);
    psel = 0; penable = 0;
  endtask

  task automatic pulse(input logic [3:0] i_sy, i_sh, i_es, i_crc, i_fix, i_unk,
                       i_fm, i_fs, i_fd, input logic i_dbl);
    @(negedge clk);
    sy = i_sy; sh = i_sh; es = i_es; crc = i_crc; fix = i_fix; unk = i_unk;
    fm = i_fm; fs = i_fs; fd = i_fd; dbl = i_dbl;
    @(negedge clk);
    sy = '0; sh = '0; es = '0; crc = '0; fix = '0; unk = '0;
    fm = '0; fs = '0; fd = '0; dbl = 1'b0;
  endtask

  // {write, addr, wdata, expected read}
  localparam int NV = 37;
  localparam logic [72:0] VEC [NV] = '{
    {1'b0, 8'h00, 32'h0,        32'h0},        // R9 version
    {1'b0, 8'h04, 32'h0,        32'h1},        // R1 lane reset
    {1'b1, 8'h04, 32'h3,        32'h0},        // R2
    {1'b0, 8'h04, 32'h0,        32'h3},
    {1'b1, 8'h04, 32'h0,        32'h0},        // R2 zero ignored
    {1'b0, 8'h04, 32'h0,        32'h3},
    {1'b1, 8'h04, 32'h5,        32'h0},        // R2 too large
    {1'b0, 8'h04, 32'h0,        32'h3},
    {1'b1, 8'h04, 32'h104,      32'h0},        // R2 upper bits set
    {1'b0, 8'h04, 32'h0,        32'h3},
    {1'b1, 8'h04, 32'h4,        32'h0},
    {1'b0, 8'h04, 32'h0,        32'h4},
    {1'b1, 8'h08, 32'h1,        32'h0},        // R3
    {1'b0, 8'h08, 32'h0,        32'h1},
    {1'b1, 8'h0C, 32'hFFFFFFFF, 32'h0},
    {1'b0, 8'h0C, 32'h0,        32'h1},
    {1'b1, 8'h10, 32'h1,        32'h0},
    {1'b0, 8'h10, 32'h0,        32'h1},
    {1'b1, 8'h14, 32'h1A5,      32'h0},
    {1'b0, 8'h14, 32'h0,        32'hA5},
    {1'b1, 8'h28, 32'hFFFFFFFF, 32'h0},        // R7 mask widths
    {1'b0, 8'h28, 32'h0,        32'hFFF},
    {1'b1, 8'h2C, 32'hFFFFFFFF, 32'h0},
    {1'b0, 8'h2C, 32'h0,        32'h01FFFFFF},
    {1'b1, 8'h28, 32'h0,        32'h0},
    {1'b1, 8'h2C, 32'h0,        32'h0},
    {1'b0, 8'h28, 32'h0,        32'h0},
    {1'b0, 8'h2C, 32'h0,        32'h0},
    {1'b0, 8'h18, 32'h0,        32'h0},        // R9 unmapped
    {1'b1, 8'h20, 32'hFFFFFFFF, 32'h0},        // R9 status write ignored
    {1'b0, 8'h20, 32'h0,        32'h0},
    {1'b0, 8'h30, 32'h0,        32'h0},
    {1'b1, 8'h00, 32'h1234,     32'h0},
    {1'b0, 8'h00, 32'h0,        32'h0},
    {1'b0, 8'h05, 32'h0,        32'h0},        // R9 misaligned
    {1'b1, 8'h06, 32'h2,        32'h0},
    {1'b0, 8'h04, 32'h0,        32'h4}
  };

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    // R1 reset state, R10 ready
    check(32'(irq), 0, "R1 irq");
    check(32'(lanes), 1, "R1 lanes");
    check({shdn, prst, crst}, 0, "R1 control bits");
    check(32'(pcfg), 0, "R1 phy cfg");
    rst_ni = 1'b1;
    @(negedge clk);
    check(32'(pready), 1, "R10 pready");

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][72]) apb_wr(VEC[i][71:64], VEC[i][63:32]);
      else begin
        apb_rd(VEC[i][71:64], d);
        check(d, VEC[i][31:0], $sformatf("register vector %0d (R1,R2,R3,R7,R9)", i));
      end
    end
    check(32'(lanes), 4, "R2 lanes port");
    check({shdn, prst, crst}, 32'h7, "R3 control ports");
    check(32'(pcfg), 32'hA5, "R3 phy cfg port");
    check(32'(irq), 0, "R9 no irq after status write");

    // R4 lane layout, R8 irq
    pulse(4'b0100, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    check(32'(irq), 1, "R8 irq after event");
    apb_rd(8'h20, d);
    check(d, 32'h4, "R4 sync-fail lane2");
    check(32'(irq), 0, "R6 irq after clear");
    apb_rd(8'h20, d);
    check(d, 32'h0, "R6 cleared");
    pulse(0, 4'b0010, 4'b1000, 0, 0, 0, 0, 0, 0, 0);
    apb_rd(8'h20, d);
    check(d, 32'h820, "R4 recovered lane1 / escape lane3");

    // R5 channel layout
    pulse(0, 0, 0, 4'b0001, 4'b0010, 4'b0100, 4'b1000, 4'b0001, 4'b0010, 1);
    apb_rd(8'h24, d);
    check(d, 32'h01218421, "R5 all groups");
    check(32'(irq), 0, "R8 irq low after read");

    // R6 independent words
    pulse(4'b0001, 0, 0, 4'b0001, 0, 0, 0, 0, 0, 0);
    apb_rd(8'h20, d);
    check(d, 32'h1, "R6 word1");
    check(32'(irq), 1, "R6 word2 kept");
    apb_rd(8'h24, d);
    check(d, 32'h1, "R6 word2");
    check(32'(irq), 0, "R8 irq low");

    // R6 event in the read cycle
    @(negedge clk);
    psel = 1; pwrite = 0; paddr = 8'h20; penable = 0;
    @(negedge clk);
    penable = 1; sy = 4'b0010;
    #1 d = prdata;
    check(d, 32'h0, "R6 same-cycle read old value");
    check(32'(pready), 1, "R10 ready in access");
    @(negedge clk);
    psel = 0; penable = 0; sy = '0;
    check(32'(irq), 1, "R6 same-cycle event kept");
    apb_rd(8'h20, d);
    check(d, 32'h2, "R6 same-cycle bit");

    // R6 sticky over idle cycles
    pulse(0, 0, 4'b0001, 0, 0, 0, 0, 0, 0, 0);
    repeat (5) @(negedge clk);
    apb_rd(8'h20, d);
    check(d, 32'h100, "R6 sticky");

    // R7 masking
    apb_wr(8'h2C, 32'h8);
    pulse(0, 0, 0, 4'b1000, 0, 0, 0, 0, 0, 0);
    check(32'(irq), 0, "R7 masked irq");
    apb_rd(8'h24, d);
    check(d, 32'h8, "R7 masked still latched");
    pulse(0, 0, 0, 4'b1000, 0, 0, 0, 0, 0, 0);
    apb_wr(8'h2C, 32'h0);
    check(32'(irq), 1, "R8 unmask raises irq");
    apb_rd(8'h24, d);
    check(32'(irq), 0, "R8 irq low");
    apb_wr(8'h28, 32'h4);
    pulse(4'b0101, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    check(32'(irq), 1, "R7 unmasked lane0");
    apb_rd(8'h20, d);
    check(d, 32'h5, "R7 word1 both latched");
    pulse(0, 0, 0, 0, 0, 0, 0, 0, 4'b0001, 0);
    check(32'(irq), 1, "R8 frame data irq");
    apb_wr(8'h2C, 32'h00100000);
    check(32'(irq), 0, "R7 mask drops irq");
    apb_wr(8'h2C, 32'h0);
    check(32'(irq), 1, "R8 irq back");
    apb_rd(8'h24, d);
    check(d, 32'h00100000, "R5 frame data ch0");
    check(32'(irq), 0, "R8 irq low");
    apb_wr(8'h28, 32'h0);

    // R1 reset mid-run
    pulse(4'b1111, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    @(negedge clk); rst_ni = 1'b0;
    @(negedge clk);
    check(32'(irq), 0, "R1 irq in reset");
    check(32'(lanes), 1, "R1 lanes in reset");
    rst_ni = 1'b1;
    apb_rd(8'h08, d);
    check(d, 32'h0, "R1 shutdown after reset");
    apb_rd(8'h20, d);
    check(d, 32'h0, "R1 status after reset");

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule